// File: doc/BRIEF.md
# Six-Phase Thyristor Gate Firing Sequencer

The block turns a locked line period into six thyristor gate pulses for a three-phase bridge. It keeps its own firing reference, separate from the phase loop's predicted crossing. The reference is loaded from the predicted crossing once, when sequencing starts, and is then moved forward by one locked period per line cycle. Within each cycle six firing events fall at the reference plus a multiple of one sixth of the period plus a signed delay command. Each event raises two gates together. A programmable width later all gates drop, and that drop arms the next event.

All times are values of a free-running 16-bit timer that is shared with the capture logic, and all arithmetic wraps modulo 2^16. The delay command is read at the moment each event is compared, so a delay step of any size reaches the very next pending event and does not disturb the loop. Sequencing needs both the run command and the lock flag. When either is removed, the gates drop at once and the block returns to idle. When both are present again, the reference is loaded afresh.

Top module: `gate_sequencer`

## Requirements
- R1: After reset all six gate outputs are low and the sequencer is idle.
- R2: On the first clock where run_i and lock_i are both high while the block is idle, the firing reference is loaded with crossing_i and event index k is set to 0.
- R3: Event k (0..5) is due at reference + k*sixth_i + delay_i, computed modulo 2^16. It fires on the clock edge where timer_i equals that value, and the gates are high from the next cycle.
- R4: Event k drives exactly two gates, where gate n is bit n-1 of gates_o. The pairs for k = 0..5 are {1,6}, {1,2}, {3,2}, {3,4}, {5,4}, {5,6}. No other combination is ever driven.
- R5: On the edge where timer_i equals rise time + width_i (width_i >= 1), all gates go low and the next event index is armed. Gates only ever change between all-low and a pair.
- R6: When the pulse of event 5 ends, k returns to 0 and the reference advances by period_i modulo 2^16.
- R7: delay_i is a signed 16-bit value that is sampled while an event is pending. A step of any size therefore applies to the next event that has not yet fired.
- R8: If run_i or lock_i is low at a clock edge, all gates are low after that edge and the block is idle. Later, with run_i and lock_i both high, the reference is loaded again from crossing_i as in R2.
- R9: Event and pulse-end times that cross the 16-bit timer wrap fire at their wrapped timer value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | Run command |
| lock_i | input | 1 | Phase lock flag |
| timer_i | input | 16 | Shared free-running timer |
| crossing_i | input | 16 | Predicted zero crossing time |
| period_i | input | 16 | Locked period in timer ticks |
| sixth_i | input | 16 | One sixth of the locked period |
| delay_i | input | 16 | Signed firing delay in ticks |
| width_i | input | 16 | Gate pulse width in ticks, at least 1 |
| gates_o | output | 6 | Gate lines, bit n-1 is gate n |

## Verification
The checker verifies the following on every cycle:
- the gates only ever show zero or two active lines;
- the gates never move from one pair straight to another;
- the gates clear on the edge after run or lock is lost;
- the event index stays in range;
- a fresh reference equals the crossing input;
- the reference only moves by exactly one period, and only after event 5.

Only the bench scenarios can show that each pulse starts and ends at the arithmetically expected timer values. The same applies to delay steps, whether negative or large, taking effect at the next pending event, to events that cross the timer wrap, and to a restart reseeding the reference.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int unsigned NPH = 6;
  localparam int unsigned KW  = $clog2(NPH);

  typedef enum logic [1:0] {ST_IDLE, ST_ARMED, ST_PULSE} seq_state_e;

  // gate n maps to bit n-1
  function automatic logic [NPH-1:0] pair_of(input logic [KW-1:0] k);
    case (k)
      3'd0:    pair_of = 6'b100001;
      3'd1:    pair_of = 6'b000011;
      3'd2:    pair_of = 6'b000110;
      3'd3:    pair_of = 6'b001100;
      3'd4:    pair_of = 6'b011000;
      3'd5:    pair_of = 6'b110000;
      default: pair_of = '0;
    endcase
  endfunction
endpackage

// File: rtl/seq_sched.sv
module seq_sched import seq_pkg::*; #(
  parameter int unsigned TW = 16
) (
  input  logic [TW-1:0] ref_i,
  input  logic [KW-1:0] k_i,
  input  logic [TW-1:0] sixth_i,
  input  logic [TW-1:0] delay_i,
  output logic [TW-1:0] due_o
);
  logic [TW-1:0] part [KW];

  for (genvar b = 0; b < KW; b++) begin : g_mul
    assign part[b] = k_i[b] ? TW'(sixth_i << b) : '0;
  end

  always_comb begin
    due_o = ref_i + delay_i;
    for (int b = 0; b < KW; b++) due_o = due_o + part[b];
  end
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl import seq_pkg::*; #(
  parameter int unsigned TW = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           go_i,
  input  logic [TW-1:0]  timer_i,
  input  logic [TW-1:0]  crossing_i,
  input  logic [TW-1:0]  period_i,
  input  logic [TW-1:0]  width_i,
  input  logic           due_hit_i,
  input  logic [NPH-1:0] pair_i,
  output logic [TW-1:0]  ref_o,
  output logic [KW-1:0]  k_o,
  output logic           active_o,
  output logic [NPH-1:0] gates_o
);
  localparam logic [KW-1:0] KLAST = KW'(NPH - 1);

  seq_state_e state_q;
  logic [TW-1:0] fall_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ref_o   <= '0;
      k_o     <= '0;
      fall_q  <= '0;
      gates_o <= '0;
    end else if (!go_i) begin
      state_q <= ST_IDLE;
      k_o     <= '0;
      gates_o <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          ref_o   <= crossing_i;
          k_o     <= '0;
          state_q <= ST_ARMED;
        end
        ST_ARMED: if (due_hit_i) begin
          gates_o <= pair_i;
          fall_q  <= timer_i + width_i;
          state_q <= ST_PULSE;
        end
        ST_PULSE: if (timer_i == fall_q) begin
          gates_o <= '0;
          state_q <= ST_ARMED;
          if (k_o == KLAST) begin
            k_o   <= '0;
            ref_o <= ref_o + period_i;
          end else begin
            k_o <= k_o + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign active_o = (state_q != ST_IDLE);
endmodule

// File: rtl/gate_sequencer.sv
module gate_sequencer import seq_pkg::*; #(
  parameter int unsigned TW = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           run_i,
  input  logic           lock_i,
  input  logic [TW-1:0]  timer_i,
  input  logic [TW-1:0]  crossing_i,
  input  logic [TW-1:0]  period_i,
  input  logic [TW-1:0]  sixth_i,
  input  logic [TW-1:0]  delay_i,
  input  logic [TW-1:0]  width_i,
  output logic [NPH-1:0] gates_o
);
  logic [TW-1:0] ref_q;
  logic [KW-1:0] k_q;
  logic          active_q;
  logic [TW-1:0] due;

  seq_sched #(.TW(TW)) u_sched (
    .ref_i(ref_q), .k_i(k_q), .sixth_i(sixth_i), .delay_i(delay_i), .due_o(due)
  );

  seq_ctrl #(.TW(TW)) u_ctrl (
    .clk_i, .rst_ni,
    .go_i(run_i && lock_i),
    .timer_i, .crossing_i, .period_i, .width_i,
    .due_hit_i(timer_i == due),
    .pair_i(pair_of(k_q)),
    .ref_o(ref_q), .k_o(k_q), .active_o(active_q), .gates_o
  );
endmodule

// File: rtl/seq_chk.sv
module seq_chk import seq_pkg::*; #(
  parameter int unsigned TW = 16
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           run_i,
  input logic           lock_i,
  input logic [TW-1:0]  crossing_i,
  input logic [TW-1:0]  period_i,
  input logic [NPH-1:0] gates_o,
  input logic [TW-1:0]  ref_q,
  input logic [KW-1:0]  k_q,
  input logic           active_q
);
  AST_RESET_IDLE: assert property (@(posedge clk_i) !rst_ni |-> gates_o == '0); // R1
  AST_SEED_REF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !$past(active_q)) |-> ref_q == $past(crossing_i)); // R2
  AST_K_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    k_q < KW'(NPH)); // R3
  AST_PAIR_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(gates_o) == 0) || ($countones(gates_o) == 2)); // R4
  AST_NO_PAIR_SWAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gates_o != $past(gates_o)) |-> (gates_o == '0 || $past(gates_o) == '0)); // R5
  AST_REF_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && $past(active_q) && ref_q != $past(ref_q))
      |-> (ref_q == TW'($past(ref_q) + $past(period_i)) && $past(k_q) == KW'(NPH - 1))); // R6
  AST_STOP_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(run_i && lock_i) |=> (gates_o == '0 && !active_q)); // R8
endmodule

bind gate_sequencer seq_chk #(.TW(TW)) u_seq_chk (.*);

// File: tb/test_gate_sequencer.sv
module test_gate_sequencer;
  logic clk = 0, rst_ni = 0, run = 0, lock = 0;
  logic [15:0] t = 0, crossing = 0, per = 600, six = 100, dly = 0, wid = 20;
  logic [5:0] gates;
  int checks = 0, fails = 0;
  bit act = 0, done = 0;
  int base = 0, d1 = 0, d2 = 0, esw = 99, ne = 12;

  always #5 clk = ~clk;

  gate_sequencer i_gate_sequencer (
    .clk_i(clk), .rst_ni, .run_i(run), .lock_i(lock), .timer_i(t),
    .crossing_i(crossing), .period_i(per), .sixth_i(six), .delay_i(dly),
    .width_i(wid), .gates_o(gates)
  );

  function automatic logic [5:0] pair(int k);
    case (k)
      0: return 6'b100001; 1: return 6'b000011; 2: return 6'b000110;
      3: return 6'b001100; 4: return 6'b011000; default: return 6'b110000;
    endcase
  endfunction

  function automatic logic [5:0] expect_at(logic [15:0] tv);
    logic [5:0] r;
    r = '0;
    if (!act) return r;
    for (int e = 0; e < ne; e++) begin
      logic [15:0] tt;
      tt = 16'(base + (e / 6) * int'(per) + (e % 6) * int'(six) + ((e >= esw) ? d2 : d1));
      if (16'(tv - tt) < wid) r |= pair(e % 6);
    end
    return r;
  endfunction

  task automatic chk(string tag, logic [5:0] got, logic [5:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s t=%0d gates=%b expected=%b", tag, t, got, exp);
    end
  endtask

  task automatic adv(string tag);
    @(negedge clk);
    chk(tag, gates, expect_at(t));
    t = t + 16'd1;
  endtask

  task automatic run_to(int target, string tag);
    while (t != 16'(target)) adv(tag);
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", gates, 6'b0);
    rst_ni = 1;
    repeat (2) adv("R1 idle");

    // S1: start, pair order, ref advance, negative delay step
    t = 900; crossing = 1000; base = 1000; per = 600; six = 100; wid = 20;
    d1 = 40; d2 = 40; esw = 99; ne = 12; dly = 16'(d1);
    run = 1; lock = 1; act = 1;
    run_to(base + 600, "R3/R4 first cycle");
    run_to(base + 765, "R6 ref advance");
    d2 = -30; esw = 8; dly = 16'(d2);
    run_to(base + 1150, "R7 negative step");
    run = 0; act = 0;
    repeat (30) adv("R8 run removed");

    // S2: wrap, large positive step, lock lost mid-pulse
    t = 65300; crossing = 65400; base = 65400;
    d1 = 300; d2 = 300; esw = 99; ne = 12; dly = 16'(d1);
    run = 1; lock = 1; act = 1;
    run_to(base + 530, "R9 wrap");
    d2 = 900; esw = 3; dly = 16'(d2);
    run_to(base + 2010, "R7 large step");
    lock = 0; act = 0;
    repeat (300) adv("R8 lock lost");

    // S3: restart reseeds from new crossing
    crossing = t + 16'd50; base = int'(t) + 50;
    per = 300; six = 50; wid = 10; d1 = 0; d2 = 0; esw = 99; ne = 6; dly = 0;
    lock = 1; act = 1;
    run_to(base + 290, "R2 reseed R5 width");
    run = 0; act = 0;
    repeat (20) adv("R8 stop");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule